// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table with 4 KiB pages, one table entry at a time. Each request carries the virtual address, the access kind, the effective privilege, the permit-user-access (SUM) and make-executable-readable (MXR) bits, the root page number and the paging mode. The walker reads table entries through a simple memory port. It applies every leaf and pointer rule, and writes an entry back when its accessed or dirty flag has to be set. It then returns one response: success or fault, the physical address, and the read, write and execute rights that a caller can install in its own cache.

Entries are 32 bits wide. The flags occupy bits 0 to 7: valid (0), readable (1), writable (2), executable (3), user (4), global (5), accessed (6) and dirty (7). The physical page number (PPN) starts at bit 10.

Top module: `pt_walker`

## Requirements
- R1: When `req_paged` is 0, or `req_priv[1]` is 1 (machine privilege), the response arrives in the cycle after acceptance. It reports no fault, a physical address equal to the zero-extended virtual address, and all three rights set. No memory access takes place.
- R2: The first entry is read at `{req_root_ppn, 12'h000} + 4*va[31:22]`. A pointer at that level leads to the second entry, read at `{ppn, 12'h000} + 4*va[21:12]`.
- R3: An entry with the valid bit clear causes a fault. A valid entry with bits 1 to 3 all clear is a pointer. A pointer found at the second level causes a fault, because no level is left.
- R4: A leaf with W set and R clear is reserved and causes a fault. This covers both the write-only and the write-execute encodings.
- R5: Privilege encoding is 0 = user and 1 = supervisor. A user page faults for supervisor privilege unless SUM is set. A user page always faults for a supervisor fetch. A non-user page faults for user privilege.
- R6: A leaf at the first level whose PPN bits 9:0 are not all zero is a misaligned superpage and causes a fault.
- R7: Access kind encoding is 0 = load, 1 = store, 2 or 3 = fetch. A load needs R, or X with MXR set. A store needs W. A fetch needs X. A missing right causes a fault.
- R8: A permitted leaf gets the accessed bit set, and also the dirty bit on a store. If this changes the entry, the new value is written to the same address before the response. Otherwise no write is made.
- R9: A second-level leaf gives `{ppn, va[11:0]}`. A first-level leaf gives `{ppn[21:10], va[21:0]}`.
- R10: Read is reported as R or (X and MXR). Execute is reported as X. Write is reported only when W is set and the access is a store or the entry's dirty bit was already set.
- R11: A memory error on any table read or on the write-back causes a fault.
- R12: `req_ready` is high only when idle. `rsp_valid` lasts one cycle. A faulting response carries address 0 and no rights. `mem_req`, `mem_we` and `mem_addr` stay fixed until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, accepts a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2/3 fetch |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, bit 1 set machine |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_paged | input | 1 | 1 two-level paging, 0 bare |
| req_root_ppn | input | 22 | Page number of the root table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 34 | Entry address |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed (valid with ack) |
| mem_rdata | input | 32 | Entry value read (valid with ack) |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read right |
| rsp_w | output | 1 | Write right |
| rsp_x | output | 1 | Execute right |

## Verification
The bench aims at the cases where one wrong flag test quietly turns a fault into a grant. These include reserved write-only leaves, user pages reached from supervisor with and without SUM, and supervisor fetches from user pages. A decoder that got any of these wrong would hand out rights it must refuse. Misaligned superpages and pointers found at the last level are covered as well. If these were missed, the walker would return an address built from the wrong bits, or would read past the table. For accessed and dirty handling, the bench checks the word left in its memory. It also checks that write is reported only when dirty is already set or the access is a store. A design that skipped the write-back, or always reported write, would let later stores bypass the dirty update. Injected memory errors on the read and the write-back must both end in a fault.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFS_W = 12,
  parameter int IDX_W = 10,
  parameter int PPN_W = 22
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [OFS_W+2*IDX_W-1:0]    req_vaddr,
  input  logic [1:0]                  req_kind,
  input  logic [1:0]                  req_priv,
  input  logic                        req_sum,
  input  logic                        req_mxr,
  input  logic                        req_paged,
  input  logic [PPN_W-1:0]            req_root_ppn,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [PPN_W+OFS_W-1:0]      mem_addr,
  output logic [PPN_W+9:0]            mem_wdata,
  input  logic                        mem_ack,
  input  logic                        mem_err,
  input  logic [PPN_W+9:0]            mem_rdata,
  output logic                        rsp_valid,
  output logic                        rsp_fault,
  output logic [PPN_W+OFS_W-1:0]      rsp_paddr,
  output logic                        rsp_r,
  output logic                        rsp_w,
  output logic                        rsp_x
);
  localparam int VA_W  = OFS_W + 2*IDX_W;
  localparam int PTE_W = PPN_W + 10;
  localparam int PA_W  = PPN_W + OFS_W;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_EVAL, S_WRITE, S_RESP} st_t;
  st_t st;

  logic [VA_W-1:0]  q_va;
  logic [1:0]       q_kind;
  logic             q_sup, q_sum, q_mxr;
  logic [PA_W-1:0]  base;
  logic             top;
  logic [PTE_W-1:0] pte;

  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] ppn;
  logic f_v, f_r, f_w, f_x, f_u, f_d;
  logic is_load, is_store, is_fetch;
  logic is_ptr, bad_rsvd, bad_user, bad_align, bad_acc, leaf_bad;
  logic [PTE_W-1:0] new_pte;
  logic [PA_W-1:0]  leaf_pa;

  assign idx      = top ? q_va[VA_W-1 -: IDX_W] : q_va[OFS_W +: IDX_W];
  assign mem_addr = base + PA_W'({idx, 2'b00});
  assign mem_req  = (st == S_READ) || (st == S_WRITE);
  assign mem_we   = (st == S_WRITE);
  assign mem_wdata = pte;
  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);

  assign ppn = pte[PTE_W-1:10];
  assign {f_d, f_u, f_x, f_w, f_r, f_v} = {pte[7], pte[4], pte[3], pte[2], pte[1], pte[0]};
  assign is_load  = (q_kind == 2'b00);
  assign is_store = (q_kind == 2'b01);
  assign is_fetch = q_kind[1];

  assign is_ptr    = !f_r && !f_w && !f_x;
  assign bad_rsvd  = f_w && !f_r;
  assign bad_user  = f_u ? (q_sup && (!q_sum || is_fetch)) : !q_sup;
  assign bad_align = top && (|ppn[IDX_W-1:0]);
  assign bad_acc   = is_load  ? !(f_r || (f_x && q_mxr)) :
                     is_store ? !f_w : !f_x;
  assign leaf_bad  = bad_rsvd || bad_user || bad_align || bad_acc;

  assign new_pte = pte | PTE_W'(8'h40) | (is_store ? PTE_W'(8'h80) : '0);
  assign leaf_pa = top ? {ppn[PPN_W-1:IDX_W], q_va[OFS_W +: IDX_W], q_va[OFS_W-1:0]}
                       : {ppn, q_va[OFS_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      q_va <= '0; q_kind <= '0; q_sup <= 1'b0; q_sum <= 1'b0; q_mxr <= 1'b0;
      base <= '0; top <= 1'b0; pte <= '0;
      rsp_fault <= 1'b0; rsp_paddr <= '0;
      rsp_r <= 1'b0; rsp_w <= 1'b0; rsp_x <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          q_va   <= req_vaddr;
          q_kind <= req_kind;
          q_sup  <= req_priv[0];
          q_sum  <= req_sum;
          q_mxr  <= req_mxr;
          if (!req_paged || req_priv[1]) begin
            rsp_fault <= 1'b0;
            rsp_paddr <= PA_W'(req_vaddr);
            {rsp_r, rsp_w, rsp_x} <= 3'b111;
            st <= S_RESP;
          end else begin
            base <= {req_root_ppn, {OFS_W{1'b0}}};
            top  <= 1'b1;
            st   <= S_READ;
          end
        end
        S_READ: if (mem_ack) begin
          if (mem_err) begin
            rsp_fault <= 1'b1; rsp_paddr <= '0; {rsp_r, rsp_w, rsp_x} <= 3'b000;
            st <= S_RESP;
          end else begin
            pte <= mem_rdata;
            st  <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (f_v && is_ptr && top) begin
            base <= {ppn, {OFS_W{1'b0}}};
            top  <= 1'b0;
            st   <= S_READ;
          end else if (!f_v || is_ptr || leaf_bad) begin
            rsp_fault <= 1'b1; rsp_paddr <= '0; {rsp_r, rsp_w, rsp_x} <= 3'b000;
            st <= S_RESP;
          end else begin
            rsp_fault <= 1'b0;
            rsp_paddr <= leaf_pa;
            rsp_r <= f_r || (f_x && q_mxr);
            rsp_w <= f_w && (is_store || f_d);
            rsp_x <= f_x;
            if (new_pte != pte) begin
              pte <= new_pte;
              st  <= S_WRITE;
            end else begin
              st <= S_RESP;
            end
          end
        end
        S_WRITE: if (mem_ack) begin
          if (mem_err) begin
            rsp_fault <= 1'b1; rsp_paddr <= '0; {rsp_r, rsp_w, rsp_x} <= 3'b000;
          end
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_props.sv
module pt_walker_props #(
  parameter int PA_W  = 34,
  parameter int PTE_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [PA_W-1:0] mem_addr,
  input logic [PTE_W-1:0] mem_wdata,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_r,
  input logic            rsp_w,
  input logic            rsp_x
);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rsp_r && !rsp_w && !rsp_x && rsp_paddr == '0));

  a_r8_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[6]);
endmodule

bind pt_walker pt_walker_props #(.PA_W(PPN_W + OFS_W), .PTE_W(PPN_W + 10)) u_props (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind, req_priv;
  logic        req_sum, req_mxr, req_paged;
  logic [21:0] req_root_ppn;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [33:0] rsp_paddr;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
    .req_sum(req_sum), .req_mxr(req_mxr), .req_paged(req_paged),
    .req_root_ppn(req_root_ppn), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_r(rsp_r),
    .rsp_w(rsp_w), .rsp_x(rsp_x)
  );

  int checks = 0;
  int errors = 0;
  int memcyc = 0;
  logic [31:0] mem [logic [33:0]];
  bit rd_err [logic [33:0]];
  bit wr_err [logic [33:0]];
  localparam logic [21:0] ROOT = 22'h100;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      memcyc++;
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem_err <= wr_err.exists(mem_addr);
        if (!wr_err.exists(mem_addr)) mem[mem_addr] = mem_wdata;
      end else begin
        mem_err   <= rd_err.exists(mem_addr);
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end else begin
      if (mem_req) memcyc++;
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [31:0] mkpte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  function automatic logic [33:0] l1a(input int vpn);
    return {ROOT, 12'h0} + 34'(vpn * 4);
  endfunction

  function automatic void model(input logic [31:0] va, input logic [1:0] kind,
      input logic [1:0] priv, input bit sum, input bit mxr, input bit paged,
      input logic [21:0] root, output logic [37:0] exp, output bit wb,
      output logic [33:0] wa, output logic [31:0] wv);
    logic [33:0] base, a, pa;
    logic [31:0] p, nv;
    logic [9:0] idx;
    wb = 0; wa = '0; wv = '0;
    if (!paged || priv[1]) begin exp = {1'b0, 2'b00, va, 3'b111}; return; end
    exp = {1'b1, 37'b0};
    base = {root, 12'h0};
    for (int l = 1; l >= 0; l--) begin
      idx = (l == 1) ? va[31:22] : va[21:12];
      a = base + {22'h0, idx, 2'b00};
      if (rd_err.exists(a)) return;
      p = mem.exists(a) ? mem[a] : 32'h0;
      if (!p[0]) return;
      if (!p[1] && !p[2] && !p[3]) begin
        if (l == 0) return;
        base = {p[31:10], 12'h0};
        continue;
      end
      if (p[2] && !p[1]) return;
      if (p[4]) begin
        if (priv == 2'd1 && (!sum || kind[1])) return;
      end else if (priv != 2'd1) return;
      if (l == 1 && p[19:10] != 10'h0) return;
      if (kind == 2'd0 && !(p[1] || (p[3] && mxr))) return;
      if (kind == 2'd1 && !p[2]) return;
      if (kind[1] && !p[3]) return;
      nv = p | 32'h40 | ((kind == 2'd1) ? 32'h80 : 32'h0);
      if (nv != p) begin
        if (wr_err.exists(a)) return;
        wb = 1; wa = a; wv = nv;
      end
      pa = (l == 1) ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
      exp = {1'b0, pa, p[1] | (p[3] & mxr), p[2] & ((kind == 2'd1) | p[7]), p[3]};
      return;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                     input bit sum, input bit mxr, input bit paged, input string req);
    logic [37:0] exp, act;
    bit wb;
    logic [33:0] wa;
    logic [31:0] wv;
    int start, n;
    model(va, kind, priv, sum, mxr, paged, ROOT, exp, wb, wa, wv);
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_priv = priv; req_sum = sum;
    req_mxr = mxr; req_paged = paged; req_root_ppn = ROOT; req_valid = 1'b1;
    start = memcyc;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 40) begin
      chk(!req_ready, "R12", "ready while busy", 64'(req_ready), 64'd0);
      @(negedge clk); n++;
    end
    act = {rsp_fault, rsp_paddr, rsp_r, rsp_w, rsp_x};
    chk(rsp_valid && act == exp, req, "response {fault,pa,r,w,x}", 64'(act), 64'(exp));
    if (!paged || priv[1])
      chk(memcyc == start, "R1", "memory cycles on bypass", 64'(memcyc - start), 64'd0);
    @(negedge clk);
    chk(!rsp_valid, "R12", "response pulse length", 64'(rsp_valid), 64'd0);
    if (wb)
      chk(mem[wa] == wv, "R8", "written-back entry", 64'(mem[wa]), 64'(wv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_priv = '0;
    req_sum = 1'b0; req_mxr = 1'b0; req_paged = 1'b0; req_root_ppn = '0;

    mem[l1a(1)] = mkpte(22'h200, 8'h01);
    mem[34'h20000C] = mkpte(22'h12345, 8'hD7);
    mem[34'h200010] = mkpte(22'h00777, 8'h17);
    mem[l1a(2)] = mkpte(22'h400, 8'hCF);
    mem[l1a(3)] = mkpte(22'h401, 8'hCF);
    mem[l1a(6)] = mkpte(22'h300, 8'h01);
    mem[34'h300000] = mkpte(22'h001, 8'h01);
    mem[l1a(7)] = mkpte(22'h800, 8'h45);
    mem[l1a(8)] = mkpte(22'h800, 8'h4D);
    mem[l1a(9)] = mkpte(22'hC00, 8'h5B);
    mem[l1a(10)] = mkpte(22'h1000, 8'h43);
    mem[l1a(11)] = mkpte(22'h1400, 8'h49);
    mem[l1a(12)] = mkpte(22'h1800, 8'hC7);
    mem[l1a(13)] = mkpte(22'h1800, 8'hC7);
    rd_err[l1a(13)] = 1'b1;
    mem[l1a(14)] = mkpte(22'h1C00, 8'h07);
    wr_err[l1a(14)] = 1'b1;
    for (int i = 16; i < 48; i++)
      mem[l1a(i)] = mkpte(22'(i * 'h400 + ((i % 3 == 0) ? 1 : 0)), 8'((i * 37) | 1));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R12", "reset state {ready,rsp,mem}",
        64'({req_ready, rsp_valid, mem_req}), 64'(3'b100));

    run(32'hDEADBEEF, 2'd1, 2'd0, 0, 0, 0, "R1");
    run(32'h12345678, 2'd2, 2'd3, 0, 0, 1, "R1");
    run(32'h00403ABC, 2'd0, 2'd0, 0, 0, 1, "R2");
    run(32'h00404010, 2'd0, 2'd0, 0, 0, 1, "R8");
    run(32'h00404010, 2'd1, 2'd0, 0, 0, 1, "R10");
    run(32'h00812345, 2'd2, 2'd1, 0, 0, 1, "R9");
    run(32'h00C00000, 2'd0, 2'd1, 0, 0, 1, "R6");
    run(32'h01400000, 2'd0, 2'd1, 0, 0, 1, "R3");
    run(32'h01800000, 2'd0, 2'd1, 0, 0, 1, "R3");
    run(32'h01C00000, 2'd1, 2'd1, 0, 0, 1, "R4");
    run(32'h02000000, 2'd2, 2'd1, 0, 0, 1, "R4");
    run(32'h02400000, 2'd0, 2'd1, 0, 0, 1, "R5");
    run(32'h02400000, 2'd0, 2'd1, 1, 0, 1, "R5");
    run(32'h02400000, 2'd2, 2'd1, 1, 0, 1, "R5");
    run(32'h02400000, 2'd2, 2'd0, 0, 0, 1, "R5");
    run(32'h02800000, 2'd0, 2'd0, 0, 0, 1, "R5");
    run(32'h02C00000, 2'd0, 2'd1, 0, 0, 1, "R7");
    run(32'h02C00000, 2'd0, 2'd1, 0, 1, 1, "R7");
    run(32'h02C00000, 2'd1, 2'd1, 0, 1, 1, "R7");
    run(32'h03000000, 2'd3, 2'd1, 0, 0, 1, "R7");
    run(32'h03400000, 2'd0, 2'd1, 0, 0, 1, "R11");
    run(32'h03800000, 2'd0, 2'd1, 0, 0, 1, "R11");

    for (int i = 16; i < 48; i++)
      for (int k = 0; k < 3; k++)
        for (int m = 0; m < 8; m++)
          run({10'(i), 10'h155, 12'h9A4}, 2'(k), 2'(m & 1), m[1], m[2], 1, "R5/R7/R10 sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule